// File: doc/BRIEF.md
# Asynchronous SRAM-Bus Bridge to Dual-Port Word Memory

This block lets an external processor reach an on-chip 32-bit word memory as if it were a plain asynchronous static RAM. The processor drives active-low chip-select, output-enable and write-enable strobes, a word address and a shared data bus. On-chip logic reaches the same storage through a second, fully synchronous port with its own address, data and control lines. Both ports may read or write in the same clock cycle.

The strobes are not related to the fabric clock. Each one passes through a two-flop synchroniser. The block then acts on the first cycle in which a synchronised access becomes active. A write captures the address and data pins once per write strobe and commits exactly one word. A read fetches one word per strobe and presents it on the data pins. The tri-state buffer sits in the pad ring, so the block exposes the bus as separate input, output and output-enable vectors. The output enable is raised only while the raw strobes say read.

The depth is set by `AW`. The default gives 2K words, and `AW = 15` gives the full 32K-word array. When the external port and the internal port write the same word in the same cycle, the internal port's data is kept.

Top module: `sram_bus_bridge`

## Requirements
- R1: After reset, `int_rdata` is zero and `ext_data_oe` is zero while all strobes are high.
- R2: `ext_data_oe` is all ones only while `ext_cs_n` and `ext_oe_n` are low and `ext_we_n` is high. For every other strobe combination it is all zeros.
- R3: A write strobe (`ext_cs_n` and `ext_we_n` low) stores the word on `ext_data_i` at `ext_addr`. The stored word is then readable on both ports.
- R4: A read strobe (`ext_cs_n` and `ext_oe_n` low, `ext_we_n` high) held for at least 6 clock cycles presents the stored word at `ext_addr` on `ext_data_o`.
- R5: Each write strobe commits exactly one word. Changes on `ext_addr` or `ext_data_i` after the capture, while the strobe is still held, have no effect on memory.
- R6: An internal read (`int_en` high, `int_we` low) returns the word on `int_rdata` after the next clock edge. `int_rdata` holds its value between internal reads.
- R7: A word written through the internal port is returned by a later external read.
- R8: When both ports write the same address in the same cycle, the internal port's data is what the memory keeps.
- R9: Writes from both ports in the same cycle to different addresses both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs_n | input | 1 | External chip select, active low, asynchronous |
| ext_oe_n | input | 1 | External output enable, active low, asynchronous |
| ext_we_n | input | 1 | External write enable, active low, asynchronous |
| ext_addr | input | AW | External word address |
| ext_data_i | input | DW | Data from the pad input buffers |
| ext_data_o | output | DW | Data to the pad output buffers |
| ext_data_oe | output | DW | Per-bit enable of the pad output buffers |
| int_en | input | 1 | Internal port access enable |
| int_we | input | 1 | Internal port write (with `int_en`) |
| int_addr | input | AW | Internal port word address |
| int_wdata | input | DW | Internal port write data |
| int_rdata | output | DW | Internal port read data, one cycle latency |

## Verification
The main function is tried with external write-then-read round trips that use all-ones, alternating-bit and walking patterns at the lowest and highest addresses. These show whether the address and data paths are complete. Cross-port traffic in both directions shows that the two ports share one array rather than separate copies. A long write strobe with the pins changed after capture separates a single-commit design from one that writes on every synchronised cycle. Same-cycle writes, aligned to the exact cycle the external write lands, are used to tell apart the internal-wins rule from the other priority, and to confirm that writes to different addresses do not interfere. Every strobe combination is swept to check that the bus is driven only during a real read.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Synchronised copy of the three active-low external strobes.
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    localparam int STROBE_N = 3;

    // Kind of access raised towards the memory by the external side.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int LAST = STAGES;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [LAST:0] sh_d;
        logic [LAST:0] sh_q;

        always_comb begin
            sh_d = {sh_q[LAST-1:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '1;
            end else begin
                sh_q <= sh_d;
            end
        end

        assign sync_o[i] = sh_q[LAST-1];
        assign prev_o[i] = sh_q[LAST];
    end

endmodule

// File: rtl/ext_port_ctrl.sv
module ext_port_ctrl
    import bridge_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb_s,
    input  strobe_t       stb_p,
    input  logic [AW-1:0] ext_addr_i,
    input  logic [DW-1:0] ext_wdata_i,
    output logic          a_en,
    output logic          a_we,
    output logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_wdata
);
    typedef struct packed {
        acc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } areq_t;

    areq_t req_d, req_q;
    logic  rd_act_s, rd_act_p, wr_act_s, wr_act_p;
    logic  rd_fire, wr_fire;

    always_comb begin
        rd_act_s = !stb_s.cs_n && !stb_s.oe_n && stb_s.we_n;
        rd_act_p = !stb_p.cs_n && !stb_p.oe_n && stb_p.we_n;
        wr_act_s = !stb_s.cs_n && !stb_s.we_n;
        wr_act_p = !stb_p.cs_n && !stb_p.we_n;
        rd_fire  = rd_act_s && !rd_act_p;
        wr_fire  = wr_act_s && !wr_act_p;

        req_d      = req_q;
        req_d.kind = ACC_NONE;
        if (wr_fire) begin
            req_d.kind = ACC_WRITE;
            req_d.addr = ext_addr_i;
            req_d.data = ext_wdata_i;
        end else if (rd_fire) begin
            req_d.kind = ACC_READ;
            req_d.addr = ext_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{kind: ACC_NONE, addr: '0, data: '0};
        end else begin
            req_q <= req_d;
        end
    end

    assign a_en    = (req_q.kind != ACC_NONE);
    assign a_we    = (req_q.kind == ACC_WRITE);
    assign a_addr  = req_q.addr;
    assign a_wdata = req_q.data;

    AST_REQ_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        a_en |-> $past(!stb_s.cs_n)); // R3
    AST_WR_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |-> $past(!stb_s.we_n)); // R3
    AST_RD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we) |-> $past(!stb_s.oe_n && stb_s.we_n)); // R4

endmodule

// File: rtl/tdp_word_ram.sv
module tdp_word_ram #(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] a_out;
        logic [DW-1:0] b_out;
    } rd_t;

    logic [DW-1:0] mem [DEPTH];
    rd_t           rd_d, rd_q;

    // Port B is written last, so it wins a same-address collision.
    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_en && b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (a_en && !a_we) begin
            rd_d.a_out = mem[a_addr];
        end
        if (b_en && !b_we) begin
            rd_d.b_out = mem[b_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign a_rdata = rd_q.a_out;
    assign b_rdata = rd_q.b_out;

    AST_A_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && !a_we) |=> $stable(a_rdata)); // R4
    AST_B_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_en && !b_we) |=> $stable(b_rdata)); // R6

endmodule

// File: rtl/sram_bus_bridge.sv
module sram_bus_bridge
    import bridge_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_cs_n,
    input  logic          ext_oe_n,
    input  logic          ext_we_n,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_data_i,
    output logic [DW-1:0] ext_data_o,
    output logic [DW-1:0] ext_data_oe,
    input  logic          int_en,
    input  logic          int_we,
    input  logic [AW-1:0] int_addr,
    input  logic [DW-1:0] int_wdata,
    output logic [DW-1:0] int_rdata
);
    strobe_t       stb_raw, stb_s, stb_p;
    logic          a_en, a_we;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic          bus_read;

    assign stb_raw = '{cs_n: ext_cs_n, oe_n: ext_oe_n, we_n: ext_we_n};

    strobe_sync #(.W(STROBE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stb_raw),
        .sync_o  (stb_s),
        .prev_o  (stb_p)
    );

    ext_port_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_s       (stb_s),
        .stb_p       (stb_p),
        .ext_addr_i  (ext_addr),
        .ext_wdata_i (ext_data_i),
        .a_en        (a_en),
        .a_we        (a_we),
        .a_addr      (a_addr),
        .a_wdata     (a_wdata)
    );

    tdp_word_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_en    (int_en),
        .b_we    (int_we),
        .b_addr  (int_addr),
        .b_wdata (int_wdata),
        .b_rdata (int_rdata)
    );

    // Pad enable follows the raw strobes so release is immediate.
    assign bus_read    = !ext_cs_n && !ext_oe_n && ext_we_n;
    assign ext_data_oe = {DW{bus_read}};
    assign ext_data_o  = a_rdata;

endmodule

// File: tb/sim_sram_bus_bridge.sv
module sim_sram_bus_bridge;
    localparam int AW = 11;
    localparam int DW = 32;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          ext_cs_n = 1, ext_oe_n = 1, ext_we_n = 1;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_data_i = '0;
    logic [DW-1:0] ext_data_o, ext_data_oe;
    logic          int_en = 0, int_we = 0;
    logic [AW-1:0] int_addr = '0;
    logic [DW-1:0] int_wdata = '0;
    logic [DW-1:0] int_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] model [1 << AW];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic [DW-1:0] mon_val;
    event          mon_ev;

    always #2 clk = ~clk;

    sram_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
        .ext_addr(ext_addr), .ext_data_i(ext_data_i),
        .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe),
        .int_en(int_en), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: pops the expected value each time a result is observed.
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", mon_val, '0);
            end else begin
                check(tag_q.pop_front(), mon_val, exp_q.pop_front());
            end
        end
    end

    task automatic ext_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        ext_addr = a; ext_data_i = d; ext_cs_n = 0; ext_we_n = 0;
        repeat (6) @(negedge clk);
        ext_we_n = 1; ext_cs_n = 1;
        repeat (4) @(negedge clk);
        model[a] = d;
    endtask

    task automatic ext_read(logic [AW-1:0] a, string tag);
        exp_q.push_back(model[a]); tag_q.push_back(tag);
        @(negedge clk);
        ext_addr = a; ext_cs_n = 0; ext_oe_n = 0;
        repeat (6) @(negedge clk);
        check({tag, " oe during read"}, ext_data_oe, '1); // R2
        mon_val = ext_data_o; ->mon_ev;
        ext_oe_n = 1; ext_cs_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic int_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        int_en = 1; int_we = 1; int_addr = a; int_wdata = d;
        @(negedge clk);
        int_en = 0; int_we = 0;
        model[a] = d;
    endtask

    task automatic int_read(logic [AW-1:0] a, string tag);
        exp_q.push_back(model[a]); tag_q.push_back(tag);
        @(negedge clk);
        int_en = 1; int_we = 0; int_addr = a;
        @(negedge clk);
        int_en = 0;
        mon_val = int_rdata; ->mon_ev;
    endtask

    // Aligns an internal write with the cycle the external write lands.
    task automatic same_cycle_writes(logic [AW-1:0] ea, logic [DW-1:0] ed,
                                     logic [AW-1:0] ia, logic [DW-1:0] id);
        @(negedge clk);
        ext_addr = ea; ext_data_i = ed; ext_cs_n = 0; ext_we_n = 0;
        repeat (3) @(negedge clk);
        int_en = 1; int_we = 1; int_addr = ia; int_wdata = id;
        @(negedge clk);
        int_en = 0; int_we = 0;
        repeat (3) @(negedge clk);
        ext_we_n = 1; ext_cs_n = 1;
        repeat (4) @(negedge clk);
        model[ea] = ed;
        model[ia] = id;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 int_rdata after reset", int_rdata, '0);
        check("R1 oe after reset", ext_data_oe, '0);

        // R2: strobe sweep with no clock dependence.
        ext_cs_n = 1; ext_oe_n = 0; ext_we_n = 1; #1;
        check("R2 cs high", ext_data_oe, '0);
        ext_cs_n = 0; ext_oe_n = 1; ext_we_n = 1; #1;
        check("R2 oe high", ext_data_oe, '0);
        ext_cs_n = 0; ext_oe_n = 0; ext_we_n = 0; #1;
        check("R2 we low", ext_data_oe, '0);
        ext_cs_n = 0; ext_oe_n = 0; ext_we_n = 1; #1;
        check("R2 read combo", ext_data_oe, '1);
        ext_cs_n = 1; ext_oe_n = 1; ext_we_n = 1;
        repeat (4) @(negedge clk);

        // R3 / R4: external round trips with several patterns.
        ext_write(11'd0, 32'hFFFF_FFFF);
        ext_write(11'h7FF, 32'hA5A5_5A5A);
        ext_write(11'h155, 32'h0000_0001);
        ext_write(11'h2AA, 32'h8000_0000);
        ext_read(11'd0, "R4 addr 0");
        ext_read(11'h7FF, "R4 top addr");
        ext_read(11'h155, "R4 walk low");
        ext_read(11'h2AA, "R4 walk high");
        int_read(11'h7FF, "R3 ext write seen on internal");

        // R6: latency and hold.
        int_write(11'h010, 32'h1234_5678);
        int_read(11'h010, "R6 internal read");
        repeat (3) @(negedge clk);
        check("R6 rdata held", int_rdata, 32'h1234_5678);

        // R7: internal write visible externally.
        int_write(11'h020, 32'hCAFE_F00D);
        ext_read(11'h020, "R7 internal write seen externally");

        // R5: pins changed while write strobe still held.
        int_write(11'h031, 32'h5555_AAAA);
        @(negedge clk);
        ext_addr = 11'h030; ext_data_i = 32'h0BAD_0001; ext_cs_n = 0; ext_we_n = 0;
        repeat (6) @(negedge clk);
        ext_addr = 11'h031; ext_data_i = 32'hDEAD_BEEF;
        repeat (6) @(negedge clk);
        ext_we_n = 1; ext_cs_n = 1;
        repeat (4) @(negedge clk);
        model[11'h030] = 32'h0BAD_0001;
        int_read(11'h030, "R5 captured word");
        int_read(11'h031, "R5 later pins ignored");

        // R8: same address, same cycle.
        same_cycle_writes(11'h040, 32'h1111_1111, 11'h040, 32'h2222_2222);
        model[11'h040] = 32'h2222_2222;
        int_read(11'h040, "R8 internal wins collision");
        ext_read(11'h040, "R8 collision seen externally");

        // R9: different addresses, same cycle.
        same_cycle_writes(11'h050, 32'h3333_3333, 11'h051, 32'h4444_4444);
        int_read(11'h050, "R9 external half");
        int_read(11'h051, "R9 internal half");

        repeat (4) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), '0);
        finish_run();
    end

endmodule